// File: doc/BRIEF.md
# Four-Channel SPI Controller Register Bank

This block is the 32-bit register front end of a serial-peripheral controller with up to four channels. It answers bus reads and writes to a small set of controller-wide registers: identification, configuration with a self-clearing reset command, a status word, interrupt pending and mask words, a wake flag, a test-control word and a mode word. It also recognises the five-register window of each channel and forwards those accesses to the channel logic as strobes with a channel index and a register index. It does not hold any channel register itself.

Each channel reports two events to the block: its transmit buffer has drained, and its receive buffer holds a word. These set sticky bits in the pending word, four bit positions per channel, and software clears them by writing ones. One interrupt line is raised whenever a pending bit is also unmasked. In test mode the pending word can be forced to all implemented bits and then held against software clears, so that interrupt wiring can be exercised without any traffic on the serial side.

The bus uses a one-cycle request and a registered response in the next cycle. Partial-width accesses and accesses to unmapped offsets have no effect, return zero and raise the error flag in the response.

Top module: `spi_regbank`

## Requirements
- R1: After reset the mode word (offset 0x28) reads 4, and the pending word (0x18), mask word (0x1C), wake flag (0x20), test word (0x24) and configuration (0x10) read 0. The interrupt line is low.
- R2: Offset 0x00 always reads 0x91 and offset 0x14 always reads 1.
- R3: Written values are masked before they are stored: the mask word keeps bits 0x1777F, the wake flag keeps bit 0, the test word keeps bits 11:0, the mode word keeps bits 3:0 and the configuration keeps bits 0x31D.
- R4: A transmit-drained event on channel n sets pending bit 4n and a receive-full event on channel n sets pending bit 4n+2. The bits stay set until cleared.
- R5: The interrupt line is high exactly when the pending word AND the mask word is nonzero.
- R6: A write to the pending word clears every bit written as 1. If an event sets a bit in the same cycle as a clear of that bit, the bit stays set.
- R7: While mode bit 3 (test enable) and test-word bit 11 (force) are both 1, writes to the pending word clear nothing.
- R8: If the test word is written with bit 11 set while mode bit 3 is 1, or the mode word is written with bit 3 set while test-word bit 11 is 1, all bits of 0x1777F in the pending word become 1. Neither write sets them when the other bit is 0.
- R9: Writing the configuration with bit 1 set pulses soft_rst in that cycle. It returns the controller-wide registers to their R1 values and then stores the written value under the R3 mask.
- R10: Channel n's window starts at 0x2C + 0x14·n and holds five words whose register index is 0 configuration, 1 status, 2 control, 3 transmit, 4 receive. A read there pulses ch_rd with ch_sel = n and ch_reg = index and returns ch_rdata in the response. A write pulses ch_wr with ch_wdata.
- R11: Writes to 0x00, 0x14 and the channel status and receive words change nothing: ch_wr stays low and the read values are unchanged.
- R12: An access whose byte enables are not all four set is ignored. A read returns 0, a write stores nothing, and the response flags an error.
- R13: An access to an unmapped or unaligned offset returns 0 with the error flag set, and a write there stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_be | input | DATA_W/8 | Byte enables; only all-ones is accepted |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Error flag for the responded access |
| tx_empty_evt | input | NCH | Per-channel transmit-drained event pulses |
| rx_full_evt | input | NCH | Per-channel receive-full event pulses |
| irq | output | 1 | Interrupt line |
| ch_sel | output | 2 | Channel index of the current window access |
| ch_reg | output | 3 | Register index within the channel window |
| ch_rd | output | 1 | Channel register read strobe |
| ch_wr | output | 1 | Channel register write strobe |
| ch_wdata | output | DATA_W | Data for the channel write |
| ch_rdata | input | DATA_W | Channel read data, valid in the ch_rd cycle |
| soft_rst | output | 1 | Soft reset pulse to the channel logic |

## Verification
The assertions assume that the event inputs are single-cycle pulses, that a request never lasts longer than its one cycle, and that ch_rdata is settled in the cycle ch_rd is high. The bench drives every request for exactly one clock with an idle cycle after it, and it raises events only in cycles it chooses. It returns ch_rdata as a fixed function of ch_sel and ch_reg, so each channel read has a known expected value. Events are timed to land in the same cycle as clears, and the test-mode writes are issued in both orders, so the set-over-clear rule and both force paths are exercised.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int unsigned NCH_MAX    = 4;
    localparam int unsigned EVT_STRIDE = 4;

    // controller-wide offsets
    localparam int unsigned OFF_IDENT  = 'h00;
    localparam int unsigned OFF_CFG    = 'h10;
    localparam int unsigned OFF_STATE  = 'h14;
    localparam int unsigned OFF_PEND   = 'h18;
    localparam int unsigned OFF_MASK   = 'h1C;
    localparam int unsigned OFF_WAKE   = 'h20;
    localparam int unsigned OFF_TEST   = 'h24;
    localparam int unsigned OFF_MODE   = 'h28;
    localparam int unsigned WIN_BASE   = 'h2C;
    localparam int unsigned WIN_STRIDE = 'h14;

    localparam logic [31:0] PEND_IMPL  = 32'h0001_777F;
    localparam logic [31:0] CFG_KEEP   = 32'h0000_031D;
    localparam logic [31:0] IDENT_VAL  = 32'h0000_0091;
    localparam logic [31:0] STATE_VAL  = 32'h0000_0001;
    localparam logic [3:0]  MODE_INIT  = 4'h4;

    localparam int unsigned CFG_SRST_BIT  = 1;
    localparam int unsigned MODE_TEST_BIT = 3;
    localparam int unsigned TEST_FORCE_BIT = 11;

    typedef enum logic [3:0] {
        RK_NONE, RK_IDENT, RK_CFG, RK_STATE, RK_PEND,
        RK_MASK, RK_WAKE, RK_TEST, RK_MODE, RK_WIN
    } reg_kind_e;

    typedef enum logic [2:0] {
        WR_CONF = 3'd0, WR_STAT = 3'd1, WR_CTRL = 3'd2, WR_TX = 3'd3, WR_RX = 3'd4
    } win_reg_e;

    typedef struct packed {
        reg_kind_e kind;
        logic [1:0] ch;
        win_reg_e  wreg;
    } dec_t;

endpackage

// File: rtl/spi_regbank_decode.sv
module spi_regbank_decode
    import spi_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NCH    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [ADDR_W-1:0] lo_bound;
    logic [ADDR_W-1:0] rel;

    always_comb begin
        dec      = '{kind: RK_NONE, ch: 2'd0, wreg: WR_CONF};
        lo_bound = '0;
        rel      = '0;
        if (addr[1:0] == 2'b00) begin
            if      (addr == ADDR_W'(OFF_IDENT)) dec.kind = RK_IDENT;
            else if (addr == ADDR_W'(OFF_CFG))   dec.kind = RK_CFG;
            else if (addr == ADDR_W'(OFF_STATE)) dec.kind = RK_STATE;
            else if (addr == ADDR_W'(OFF_PEND))  dec.kind = RK_PEND;
            else if (addr == ADDR_W'(OFF_MASK))  dec.kind = RK_MASK;
            else if (addr == ADDR_W'(OFF_WAKE))  dec.kind = RK_WAKE;
            else if (addr == ADDR_W'(OFF_TEST))  dec.kind = RK_TEST;
            else if (addr == ADDR_W'(OFF_MODE))  dec.kind = RK_MODE;
            for (int n = 0; n < NCH; n++) begin
                lo_bound = ADDR_W'(WIN_BASE + n * WIN_STRIDE);
                if (addr >= lo_bound && addr < lo_bound + ADDR_W'(WIN_STRIDE)) begin
                    rel      = addr - lo_bound;
                    dec.kind = RK_WIN;
                    dec.ch   = 2'(n);
                    dec.wreg = win_reg_e'(rel[4:2]);
                end
            end
        end
    end
endmodule

// File: rtl/spi_irq_pending.sv
module spi_irq_pending
    import spi_regbank_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic [31:0]    pend_q,
    input  logic [NCH-1:0] tx_evt,
    input  logic [NCH-1:0] rx_evt,
    input  logic           clr_req,
    input  logic [31:0]    clr_bits,
    input  logic           lock,
    input  logic           force_all,
    output logic [31:0]    pend_d
);
    logic [EVT_STRIDE-1:0] slice [NCH_MAX];
    logic [31:0]           evt_vec;
    logic [31:0]           kept;

    for (genvar n = 0; n < NCH_MAX; n++) begin : g_slice
        if (n < NCH) begin : g_live
            assign slice[n] = {1'b0, rx_evt[n], 1'b0, tx_evt[n]};
        end else begin : g_idle
            assign slice[n] = '0;
        end
    end

    assign evt_vec = {16'h0000, slice[3], slice[2], slice[1], slice[0]};

    always_comb begin
        kept = pend_q;
        if (clr_req && !lock) kept = kept & ~clr_bits;
        if (force_all)        kept = kept | PEND_IMPL;
        pend_d = (kept | evt_vec) & PEND_IMPL;
    end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_regbank_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic [NCH-1:0]    tx_empty_evt,
    input  logic [NCH-1:0]    rx_full_evt,
    output logic              irq,
    output logic [1:0]        ch_sel,
    output logic [2:0]        ch_reg,
    output logic              ch_rd,
    output logic              ch_wr,
    output logic [DATA_W-1:0] ch_wdata,
    input  logic [DATA_W-1:0] ch_rdata,
    output logic              soft_rst
);
    localparam int unsigned BE_W = DATA_W / 8;
    localparam int unsigned TEST_W = 12;
    localparam int unsigned MODE_W = 4;

    typedef struct packed {
        logic [31:0]       cfg;
        logic [31:0]       pend;
        logic [31:0]       mask;
        logic              wake;
        logic [TEST_W-1:0] test;
        logic [MODE_W-1:0] mode;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
    } state_t;

    localparam state_t STATE_RST = '{
        cfg: '0, pend: '0, mask: '0, wake: 1'b0, test: '0,
        mode: MODE_INIT, rsp_valid: 1'b0, rsp_err: 1'b0, rsp_rdata: '0
    };

    state_t q, d;
    dec_t   dec;
    logic   full_acc, acc_ok, wr_ok, rd_ok;
    logic   test_lock, clr_req, force_all;
    logic [31:0] pend_next;

    spi_regbank_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign full_acc  = (bus_be == {BE_W{1'b1}});
    assign acc_ok    = bus_req && full_acc && (dec.kind != RK_NONE);
    assign wr_ok     = acc_ok && bus_we;
    assign rd_ok     = acc_ok && !bus_we;
    assign test_lock = q.mode[MODE_TEST_BIT] && q.test[TEST_FORCE_BIT];
    assign clr_req   = wr_ok && (dec.kind == RK_PEND);
    assign force_all = wr_ok &&
        (((dec.kind == RK_TEST) && q.mode[MODE_TEST_BIT] && bus_wdata[TEST_FORCE_BIT]) ||
         ((dec.kind == RK_MODE) && bus_wdata[MODE_TEST_BIT] && q.test[TEST_FORCE_BIT]));
    assign soft_rst  = wr_ok && (dec.kind == RK_CFG) && bus_wdata[CFG_SRST_BIT];

    spi_irq_pending #(.NCH(NCH)) u_pend (
        .pend_q    (q.pend),
        .tx_evt    (tx_empty_evt),
        .rx_evt    (rx_full_evt),
        .clr_req   (clr_req),
        .clr_bits  (bus_wdata[31:0]),
        .lock      (test_lock),
        .force_all (force_all),
        .pend_d    (pend_next)
    );

    always_comb begin
        d           = q;
        d.pend      = pend_next;
        d.rsp_valid = bus_req;
        d.rsp_err   = bus_req && !acc_ok;
        d.rsp_rdata = '0;

        if (wr_ok) begin
            case (dec.kind)
                RK_CFG:  d.cfg  = bus_wdata[31:0] & CFG_KEEP;
                RK_MASK: d.mask = bus_wdata[31:0] & PEND_IMPL;
                RK_WAKE: d.wake = bus_wdata[0];
                RK_TEST: d.test = bus_wdata[TEST_W-1:0];
                RK_MODE: d.mode = bus_wdata[MODE_W-1:0];
                default: ;
            endcase
        end

        if (rd_ok) begin
            case (dec.kind)
                RK_IDENT: d.rsp_rdata = DATA_W'(IDENT_VAL);
                RK_CFG:   d.rsp_rdata = DATA_W'(q.cfg);
                RK_STATE: d.rsp_rdata = DATA_W'(STATE_VAL);
                RK_PEND:  d.rsp_rdata = DATA_W'(q.pend);
                RK_MASK:  d.rsp_rdata = DATA_W'(q.mask);
                RK_WAKE:  d.rsp_rdata = DATA_W'(q.wake);
                RK_TEST:  d.rsp_rdata = DATA_W'(q.test);
                RK_MODE:  d.rsp_rdata = DATA_W'(q.mode);
                RK_WIN:   d.rsp_rdata = ch_rdata;
                default:  d.rsp_rdata = '0;
            endcase
        end

        if (soft_rst) begin
            d.pend = '0;
            d.mask = '0;
            d.wake = 1'b0;
            d.test = '0;
            d.mode = MODE_INIT;
            d.cfg  = bus_wdata[31:0] & CFG_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= STATE_RST;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rsp_rdata;
    assign rsp_err   = q.rsp_err;
    assign irq       = |(q.pend & q.mask);

    assign ch_sel   = dec.ch;
    assign ch_reg   = dec.wreg;
    assign ch_rd    = rd_ok && (dec.kind == RK_WIN);
    assign ch_wr    = wr_ok && (dec.kind == RK_WIN) &&
                      (dec.wreg == WR_CONF || dec.wreg == WR_CTRL || dec.wreg == WR_TX);
    assign ch_wdata = bus_wdata;
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk
    import spi_regbank_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic [NCH-1:0]    tx_evt,
    input logic [NCH-1:0]    rx_evt,
    input logic              soft_rst,
    input logic              test_lock,
    input logic [31:0]       pend,
    input logic [31:0]       mask,
    input logic [3:0]        mode,
    input logic              ch_wr,
    input logic [2:0]        ch_reg,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    for (genvar n = 0; n < NCH; n++) begin : g_evt
        // R4
        tx_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_evt[n] && !soft_rst) |=> pend[EVT_STRIDE*n]);
        // R4
        rx_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_evt[n] && !soft_rst) |=> pend[EVT_STRIDE*n+2]);
    end

    // R7
    lock_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_lock && !soft_rst) |=> (($past(pend) & ~pend) == 32'h0));

    // R8
    force_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_lock) |-> (pend == PEND_IMPL));

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode == MODE_INIT && mask == 32'h0 && pend == 32'h0));

    // R11
    ro_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wr |-> (ch_reg == 3'd0 || ch_reg == 3'd2 || ch_reg == 3'd3));

    // R13
    err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R10
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_req));
endmodule

bind spi_regbank spi_regbank_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .tx_evt    (tx_empty_evt),
    .rx_evt    (rx_full_evt),
    .soft_rst  (soft_rst),
    .test_lock (test_lock),
    .pend      (q.pend),
    .mask      (q.mask),
    .mode      (q.mode),
    .ch_wr     (ch_wr),
    .ch_reg    (ch_reg),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/tb_spi_regbank.sv
`timescale 1ns/1ps
module tb_spi_regbank;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err, irq, ch_rd, ch_wr, soft_rst;
    logic [31:0] rsp_rdata, ch_wdata, ch_rdata;
    logic [3:0]  tx_evt = '0, rx_evt = '0;
    logic [1:0]  ch_sel;
    logic [2:0]  ch_reg;

    int total = 0, bad = 0;
    logic        o_valid, o_err, s_rd, s_wr, s_srst;
    logic [31:0] o_data, s_wdata;
    logic [1:0]  s_sel;
    logic [2:0]  s_reg;

    always #10 clk = ~clk;

    assign ch_rdata = 32'hC0DE_0000 | {22'h0, ch_sel, 5'h0, ch_reg};

    spi_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .tx_empty_evt(tx_evt), .rx_full_evt(rx_evt), .irq(irq),
        .ch_sel(ch_sel), .ch_reg(ch_reg), .ch_rd(ch_rd), .ch_wr(ch_wr),
        .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .soft_rst(soft_rst)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h91,    1'b0, 8'd2},  // R2
        '{1'b0, 8'h14, 4'hF, 32'h0,        32'h1,     1'b0, 8'd2},  // R2
        '{1'b1, 8'h1C, 4'hF, 32'hFFFFFFFF, 32'h0,     1'b0, 8'd3},  // R3
        '{1'b0, 8'h1C, 4'hF, 32'h0,        32'h1777F, 1'b0, 8'd3},  // R3
        '{1'b1, 8'h20, 4'hF, 32'hFFFFFFFF, 32'h0,     1'b0, 8'd3},
        '{1'b0, 8'h20, 4'hF, 32'h0,        32'h1,     1'b0, 8'd3},
        '{1'b1, 8'h24, 4'hF, 32'hFFFFF7FF, 32'h0,     1'b0, 8'd3},
        '{1'b0, 8'h24, 4'hF, 32'h0,        32'h7FF,   1'b0, 8'd3},
        '{1'b1, 8'h28, 4'hF, 32'hFFFFFFF5, 32'h0,     1'b0, 8'd3},
        '{1'b0, 8'h28, 4'hF, 32'h0,        32'h5,     1'b0, 8'd3},
        '{1'b1, 8'h10, 4'hF, 32'hFFFFFFFD, 32'h0,     1'b0, 8'd3},
        '{1'b0, 8'h10, 4'hF, 32'h0,        32'h31D,   1'b0, 8'd3},
        '{1'b1, 8'h00, 4'hF, 32'h12345678, 32'h0,     1'b0, 8'd11}, // R11
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h91,    1'b0, 8'd11},
        '{1'b1, 8'h14, 4'hF, 32'h0,        32'h0,     1'b0, 8'd11},
        '{1'b0, 8'h14, 4'hF, 32'h0,        32'h1,     1'b0, 8'd11},
        '{1'b0, 8'h04, 4'hF, 32'h0,        32'h0,     1'b1, 8'd13}, // R13
        '{1'b0, 8'h2D, 4'hF, 32'h0,        32'h0,     1'b1, 8'd13},
        '{1'b0, 8'h7C, 4'hF, 32'h0,        32'h0,     1'b1, 8'd13},
        '{1'b1, 8'h08, 4'hF, 32'hFFFF,     32'h0,     1'b1, 8'd13},
        '{1'b0, 8'h00, 4'h3, 32'h0,        32'h0,     1'b1, 8'd12}, // R12
        '{1'b1, 8'h1C, 4'h1, 32'h0,        32'h0,     1'b1, 8'd12},
        '{1'b0, 8'h1C, 4'hF, 32'h0,        32'h1777F, 1'b0, 8'd12},
        '{1'b0, 8'h18, 4'hF, 32'h0,        32'h0,     1'b0, 8'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [7:0] addr, input logic [3:0] be,
                       input logic [31:0] wd, input logic [3:0] etx, input logic [3:0] erx);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
        tx_evt = etx; rx_evt = erx;
        #2;
        s_rd = ch_rd; s_wr = ch_wr; s_sel = ch_sel; s_reg = ch_reg;
        s_wdata = ch_wdata; s_srst = soft_rst;
        @(negedge clk);
        o_valid = rsp_valid; o_data = rsp_rdata; o_err = rsp_err;
        bus_req = 1'b0; bus_we = 1'b0; tx_evt = '0; rx_evt = '0;
    endtask

    task automatic rd(input logic [7:0] addr);
        bus(1'b0, addr, 4'hF, 32'h0, 4'h0, 4'h0);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
        bus(1'b1, addr, 4'hF, wd, 4'h0, 4'h0);
    endtask

    task automatic pulse(input logic [3:0] etx, input logic [3:0] erx);
        @(negedge clk);
        tx_evt = etx; rx_evt = erx;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h28); chk("R1 mode", o_data, 32'h4);
        rd(8'h18); chk("R1 pending", o_data, 32'h0);
        rd(8'h1C); chk("R1 mask", o_data, 32'h0);
        rd(8'h20); chk("R1 wake", o_data, 32'h0);
        rd(8'h24); chk("R1 test", o_data, 32'h0);
        rd(8'h10); chk("R1 cfg", o_data, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            bus(TBL[i].we, TBL[i].addr, TBL[i].be, TBL[i].wdata, 4'h0, 4'h0);
            chk($sformatf("R%0d vec%0d valid", TBL[i].req, i), {31'h0, o_valid}, 32'h1);
            chk($sformatf("R%0d vec%0d data", TBL[i].req, i), o_data, TBL[i].exp);
            chk($sformatf("R%0d vec%0d err", TBL[i].req, i), {31'h0, o_err}, {31'h0, TBL[i].err});
        end

        // R4 events: mask is 0x1777F here
        pulse(4'b0010, 4'b1000);
        chk("R5 irq after events", {31'h0, irq}, 32'h1);
        rd(8'h18); chk("R4 bits 4 and 14", o_data, 32'h4010);
        // R6 write-one-to-clear
        wr(8'h18, 32'h10);
        rd(8'h18); chk("R6 clear bit 4", o_data, 32'h4000);
        bus(1'b1, 8'h18, 4'hF, 32'h4000, 4'h0, 4'b1000);
        rd(8'h18); chk("R6 set wins over clear", o_data, 32'h4000);
        bus(1'b1, 8'h18, 4'hF, 32'h0, 4'b0001, 4'b0100);
        rd(8'h18); chk("R4 ch0 tx ch2 rx", o_data, 32'h4401);
        // R5 masking
        wr(8'h1C, 32'h0);
        chk("R5 irq masked", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h4000);
        chk("R5 irq unmasked", {31'h0, irq}, 32'h1);
        wr(8'h1C, 32'h10);
        chk("R5 irq other bit", {31'h0, irq}, 32'h0);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18); chk("R6 clear all", o_data, 32'h0);

        // R8 / R7 test mode; mode=5 test=0x7FF now
        wr(8'h24, 32'h800);
        rd(8'h18); chk("R8 no force without test enable", o_data, 32'h0);
        wr(8'h28, 32'h8);
        rd(8'h18); chk("R8 force on mode write", o_data, 32'h1777F);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18); chk("R7 clear blocked", o_data, 32'h1777F);
        wr(8'h24, 32'h0);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18); chk("R7 clear after unlock", o_data, 32'h0);
        wr(8'h24, 32'h800);
        rd(8'h18); chk("R8 force on test write", o_data, 32'h1777F);
        wr(8'h28, 32'h0);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18); chk("R7 clear after mode off", o_data, 32'h0);

        // R10 / R11 channel windows
        for (int n = 0; n < NCH; n++) begin
            for (int r = 0; r < 5; r++) begin
                logic [7:0] a;
                logic       wexp;
                a = 8'(8'h2C + 20 * n + 4 * r);
                rd(a);
                chk($sformatf("R10 rd strobe ch%0d r%0d", n, r), {31'h0, s_rd}, 32'h1);
                chk($sformatf("R10 sel ch%0d r%0d", n, r), {27'h0, s_sel, s_reg}, {27'h0, 2'(n), 3'(r)});
                chk($sformatf("R10 rdata ch%0d r%0d", n, r), o_data,
                    32'hC0DE_0000 | (32'(n) << 8) | 32'(r));
                wexp = (r == 0 || r == 2 || r == 3);
                wr(a, 32'hA500_0000 | 32'(a));
                chk($sformatf("R11 wr strobe ch%0d r%0d", n, r), {31'h0, s_wr}, {31'h0, wexp});
                chk($sformatf("R10 no rd on write ch%0d r%0d", n, r), {31'h0, s_rd}, 32'h0);
                if (wexp)
                    chk($sformatf("R10 wdata ch%0d r%0d", n, r), s_wdata, 32'hA500_0000 | 32'(a));
            end
        end

        // R9 soft reset
        wr(8'h1C, 32'h5);
        wr(8'h28, 32'h3);
        pulse(4'b0001, 4'b0000);
        chk("R9 irq before reset", {31'h0, irq}, 32'h1);
        wr(8'h10, 32'h3);
        chk("R9 soft_rst pulse", {31'h0, s_srst}, 32'h1);
        chk("R9 irq after reset", {31'h0, irq}, 32'h0);
        rd(8'h10); chk("R9 cfg stored", o_data, 32'h1);
        rd(8'h28); chk("R9 mode reset", o_data, 32'h4);
        rd(8'h1C); chk("R9 mask reset", o_data, 32'h0);
        rd(8'h18); chk("R9 pending reset", o_data, 32'h0);
        wr(8'h10, 32'h1);
        chk("R9 no pulse without bit 1", {31'h0, s_srst}, 32'h0);

        finish_run();
    end
endmodule